// File: doc/BRIEF.md
# Two-step flash code combiner

This block sits behind the comparator banks of a two-step flash converter and turns their raw decisions into a 10-bit binary code with a separate overflow flag. The coarse bank delivers a 32-bit thermometer vector. The block encodes it and registers the count, and that registered count is also driven out to steer the fine ladder onto the matching sub-range. One clock later, the fine bank delivers its own 32-bit thermometer vector taken from that sub-range.

The block encodes the fine vector and adds it to the stored coarse count, scaled by 32. The sum is registered as the output code. A sum that reaches 1024 or more raises the overflow flag and saturates the data at full scale, so a carry out of the top can never wrap to a small code. Samples may enter on every clock, so the block produces one result per cycle, each one two edges after its coarse vector was taken.

Top module: `flash_code_combiner`

## Requirements
- R1: While reset is asserted and before any sample is taken, `code` is 0 and `code_vld`, `code_ovf` and `range_sel` are all 0.
- R2: Bit k of `coarse_therm` is 1 when the input is at or above (k+1) coarse steps. On an edge where `smp_vld` is 1, `range_sel` takes the coarse count (0 to 32). On an edge where `smp_vld` is 0, `range_sel` keeps its value.
- R3: On the edge after a sample was taken, `code` becomes 32 × `range_sel` + fine count, where the fine count comes from `fine_therm` with the same bit convention as R2.
- R4: The path is fully pipelined. A run of N consecutive valid samples yields N consecutive cycles with `code_vld` high.
- R5: A coarse vector with all 32 bits set (range 32, input at or above the top reference) gives `code_ovf` = 1 and `code` = 0x3FF.
- R6: When 32 × range + fine count is 1024 or more, `code_ovf` is 1 and `code` is 0x3FF. Below 1024, `code_ovf` is 0 and the data bits are the plain sum.
- R7: Thermometer bubbles are resolved by the highest set position. The count is the index of the highest 1 (its 1-to-0 transition) plus one, and zeros below it are ignored. This applies to both vectors.
- R8: All-zero coarse and fine vectors, for an input at or below the lower reference, give `code` = 0 and `code_ovf` = 0.
- R9: `code_vld` is high exactly two edges after an edge with `smp_vld` high, and is low otherwise. `code` and `code_ovf` hold their values in cycles without a result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| smp_vld | input | 1 | A coarse vector is present this cycle |
| coarse_therm | input | 32 | Coarse comparator thermometer vector |
| fine_therm | input | 32 | Fine comparator thermometer vector for the previous sample |
| range_sel | output | 6 | Registered coarse count, selects the fine sub-range |
| code_vld | output | 1 | A result is present on `code` |
| code | output | 10 | Binary conversion result |
| code_ovf | output | 1 | Input at or above the top reference |

## Verification
The coarse count is due on `range_sel` one edge after its vector is presented. The code, the overflow flag and `code_vld` are due on the following edge, when the fine vector for that sample is presented. The bench drives on the falling edge and advances its behavioural model at each rising edge. It compares every output at the next falling edge, so each result is checked in exactly the cycle it becomes due and never a cycle early. The directed cases for carry saturation, bubbles and top-of-range inputs are read two falling edges after their coarse vector.

// File: rtl/flash_comb_pkg.sv
package flash_comb_pkg;

   typedef enum logic {
      ENC_TOP_EDGE   = 1'b0,
      ENC_ONES_COUNT = 1'b1
   } enc_mode_e;

endpackage

// File: rtl/therm_encoder.sv
module therm_encoder #(
   parameter int                        W     = 32,
   parameter flash_comb_pkg::enc_mode_e MODE  = flash_comb_pkg::ENC_TOP_EDGE,
   parameter int                        CNT_W = $clog2(W + 1)
) (
   input  logic [W-1:0]     therm,
   output logic [CNT_W-1:0] count
);

   if (W < 2) begin : g_bad_w
      $error("therm_encoder: W must be at least 2");
   end

   if (MODE == flash_comb_pkg::ENC_TOP_EDGE) begin : g_top_edge
      // highest 1 wins: lower bubbles are ignored
      always_comb begin
         count = '0;
         for (int i = 0; i < W; i++) begin
            if (therm[i]) count = CNT_W'(i + 1);
         end
      end
   end else begin : g_ones
      always_comb begin
         count = '0;
         for (int i = 0; i < W; i++) begin
            count = count + CNT_W'(therm[i]);
         end
      end
   end

endmodule

// File: rtl/code_adder.sv
module code_adder #(
   parameter int CB    = 5,
   parameter int FB    = 5,
   parameter int OUT_W = CB + FB
) (
   input  logic [CB:0]      coarse_cnt,
   input  logic [FB:0]      fine_cnt,
   output logic [OUT_W-1:0] data,
   output logic             ovf
);

   localparam int SUM_W = OUT_W + 2;

   if (OUT_W != CB + FB) begin : g_bad_out
      $error("code_adder: OUT_W must equal CB + FB");
   end

   logic [SUM_W-1:0] sum;

   always_comb begin
      sum  = {1'b0, coarse_cnt, {FB{1'b0}}} + SUM_W'(fine_cnt);
      ovf  = |sum[SUM_W-1:OUT_W];
      data = ovf ? {OUT_W{1'b1}} : sum[OUT_W-1:0];
   end

endmodule

// File: rtl/flash_code_combiner.sv
module flash_code_combiner #(
   parameter int                        CB   = 5,
   parameter int                        FB   = 5,
   parameter flash_comb_pkg::enc_mode_e MODE = flash_comb_pkg::ENC_TOP_EDGE
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                smp_vld,
   input  logic [(1<<CB)-1:0]  coarse_therm,
   input  logic [(1<<FB)-1:0]  fine_therm,
   output logic [CB:0]         range_sel,
   output logic                code_vld,
   output logic [CB+FB-1:0]    code,
   output logic                code_ovf
);

   localparam int CW    = 1 << CB;
   localparam int FW    = 1 << FB;
   localparam int OUT_W = CB + FB;
   localparam int SUM_W = OUT_W + 2;

   if (CB < 2 || FB < 2 || CB > 8 || FB > 8) begin : g_bad_cfg
      $error("flash_code_combiner: CB and FB must lie in 2..8");
   end

   logic [CB:0]      coarse_cnt;
   logic [FB:0]      fine_cnt;
   logic [OUT_W-1:0] sum_data;
   logic             sum_ovf;
   logic             stage_vld;

   therm_encoder #(.W(CW), .MODE(MODE), .CNT_W(CB + 1)) u_coarse_enc (
      .therm (coarse_therm),
      .count (coarse_cnt)
   );

   therm_encoder #(.W(FW), .MODE(MODE), .CNT_W(FB + 1)) u_fine_enc (
      .therm (fine_therm),
      .count (fine_cnt)
   );

   code_adder #(.CB(CB), .FB(FB), .OUT_W(OUT_W)) u_add (
      .coarse_cnt (range_sel),
      .fine_cnt   (fine_cnt),
      .data       (sum_data),
      .ovf        (sum_ovf)
   );

   // stage 1: hold coarse result while the fine bank compares
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         range_sel <= '0;
         stage_vld <= 1'b0;
      end else begin
         stage_vld <= smp_vld;
         if (smp_vld) range_sel <= coarse_cnt;
      end
   end

   // stage 2: combined code
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         code     <= '0;
         code_ovf <= 1'b0;
         code_vld <= 1'b0;
      end else begin
         code_vld <= stage_vld;
         if (stage_vld) begin
            code     <= sum_data;
            code_ovf <= sum_ovf;
         end
      end
   end

   // checks
   logic [SUM_W-1:0] chk_sum;
   assign chk_sum = {1'b0, range_sel, {FB{1'b0}}} + SUM_W'(fine_cnt);

   a_r5_ovf_saturates : assert property (@(posedge clk) disable iff (!rst_n)
      code_ovf |-> (code == {OUT_W{1'b1}}));

   a_r5_top_range_flags : assert property (@(posedge clk) disable iff (!rst_n)
      (stage_vld && range_sel == (CB+1)'(CW)) |=> (code_ovf && code_vld));

   a_r3_clean_sum : assert property (@(posedge clk) disable iff (!rst_n)
      (stage_vld && chk_sum < SUM_W'(1 << OUT_W))
      |=> (!code_ovf && code == $past(chk_sum[OUT_W-1:0])));

   a_r2_range_hold : assert property (@(posedge clk) disable iff (!rst_n)
      !smp_vld |=> $stable(range_sel));

   a_r9_vld_latency : assert property (@(posedge clk) disable iff (!rst_n)
      smp_vld |-> ##2 code_vld);

   a_r9_result_hold : assert property (@(posedge clk) disable iff (!rst_n)
      !stage_vld |=> ($stable(code) && $stable(code_ovf) && !code_vld));

endmodule

// File: tb/sim_flash_code_combiner.sv
module sim_flash_code_combiner;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        smp_vld;
   logic [31:0] coarse_therm;
   logic [31:0] fine_therm;
   logic [5:0]  range_sel;
   logic        code_vld;
   logic [9:0]  code;
   logic        code_ovf;

   int errors = 0;
   int checks = 0;

   // behavioural model state
   int m_range = 0, m_svld = 0, m_code = 0, m_ovf = 0, m_cvld = 0;
   int prev_v = 0, prev_c = 0;
   int vld_seen = 0;

   always #10 clk = ~clk;

   flash_code_combiner u0 (
      .clk, .rst_n, .smp_vld, .coarse_therm, .fine_therm,
      .range_sel, .code_vld, .code, .code_ovf
   );

   function automatic int top_count(input logic [31:0] t);
      int r = 0;
      for (int i = 31; i >= 0; i--) begin
         if (t[i]) begin
            r = i + 1;
            break;
         end
      end
      return r;
   endfunction

   function automatic logic [31:0] therm_of(input int n);
      logic [32:0] t = (33'd1 << n) - 33'd1;
      return t[31:0];
   endfunction

   task automatic check(input string tag, input int act, input int exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // drive at a falling edge, model the rising edge, compare at the next falling edge
   task automatic step(input logic vld, input logic [31:0] cth, input logic [31:0] fth);
      int s;
      smp_vld = vld;
      coarse_therm = cth;
      fine_therm = fth;
      @(posedge clk);
      if (m_svld != 0) begin
         s = m_range * 32 + top_count(fth);
         if (s >= 1024) begin
            m_code = 1023;
            m_ovf = 1;
         end else begin
            m_code = s;
            m_ovf = 0;
         end
      end
      m_cvld = m_svld;
      if (vld) m_range = top_count(cth);
      m_svld = vld ? 1 : 0;
      @(negedge clk);
      check("R2 range_sel", int'(range_sel), m_range);
      check("R3 code", int'(code), m_code);
      check("R6 code_ovf", int'(code_ovf), m_ovf);
      check("R9 code_vld", int'(code_vld), m_cvld);
      if (code_vld) vld_seen++;
   endtask

   // ideal input value in LSB units; fine vector follows the previous sample
   task automatic run_value(input logic vld, input int v);
      int vc, c, f;
      vc = (v < 0) ? 0 : v;
      c = vc / 32;
      if (c > 32) c = 32;
      f = prev_v - 32 * prev_c;
      if (f < 0) f = 0;
      if (f > 32) f = 32;
      step(vld, therm_of(c), therm_of(f));
      if (vld) begin
         prev_v = vc;
         prev_c = c;
      end
   endtask

   initial begin
      #(20 * 100000);
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      rst_n = 1'b0;
      smp_vld = 1'b0;
      coarse_therm = '0;
      fine_therm = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1 reset state
      check("R1 code", int'(code), 0);
      check("R1 code_vld", int'(code_vld), 0);
      check("R1 code_ovf", int'(code_ovf), 0);
      check("R1 range_sel", int'(range_sel), 0);
      rst_n = 1'b1;

      // R8 zero input
      run_value(1'b1, 0);
      run_value(1'b0, 0);
      check("R8 code zero", int'(code), 0);
      check("R8 no ovf", int'(code_ovf), 0);

      // R4 streaming ramp and scattered values
      vld_seen = 0;
      for (int i = 0; i < 150; i++) begin
         run_value(1'b1, (i * 37 + 11) % 1100);
      end
      run_value(1'b0, 0);
      check("R4 results in stream", vld_seen, 150);

      // R9 idle cycles hold range and code
      run_value(1'b0, 0);
      run_value(1'b0, 0);

      // R5 input above top reference
      run_value(1'b1, 1100);
      run_value(1'b0, 0);
      check("R5 code full", int'(code), 1023);
      check("R5 ovf", int'(code_ovf), 1);

      // R6 carry of fine into the top: 31*32 + 32 = 1024
      step(1'b1, 32'h7FFF_FFFF, 32'h0);
      step(1'b0, 32'h0, 32'hFFFF_FFFF);
      check("R6 carry saturates", int'(code), 1023);
      check("R6 carry ovf", int'(code_ovf), 1);

      // R6 just below: 31*32 + 31 = 1023
      step(1'b1, 32'h7FFF_FFFF, 32'h0);
      step(1'b0, 32'h0, 32'h7FFF_FFFF);
      check("R6 top code", int'(code), 1023);
      check("R6 top no ovf", int'(code_ovf), 0);

      // R7 bubbles: coarse 0xB7 -> 8, fine 0xD1F -> 12, code 268
      step(1'b1, 32'h0000_00B7, 32'h0);
      check("R7 coarse bubble", int'(range_sel), 8);
      step(1'b0, 32'h0, 32'h0000_0D1F);
      check("R7 fine bubble", int'(code), 268);
      check("R7 no ovf", int'(code_ovf), 0);

      // R2 hold while smp_vld low, even with a changing coarse vector
      step(1'b0, 32'hFFFF_FFFF, 32'h0);
      check("R2 range held", int'(range_sel), 8);
      check("R9 no result", int'(code_vld), 0);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule